// File: doc/BRIEF.md
# Precise exception flush controller

This block keeps exceptions precise in a five-stage in-order pipeline (stage 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback). Every cycle each stage may raise an exception flag, and it supplies its instruction's PC and a 4-bit cause code. The block owns the per-stage valid bits. It tracks the oldest excepting instruction as that instruction moves down the pipe. It kills every younger instruction and lets the older ones drain. Older instructions can still raise their own exceptions, and such an exception displaces the recorded one.

When the tracked instruction sits in writeback, the exception commits. On the next cycle the block pulses a fetch redirect to a fixed handler vector and shows the saved resume PC and cause. The block also gates the register-file write enable, which is used in writeback, and the memory write enable, which is used in the memory stage. Neither enable can then fire for an excepting instruction or for any instruction younger than one.

Top module: `exc_flush_ctrl`

## Requirements
- R1: After reset, all stage valid bits, redirect_o, epc_o, cause_o, rf_we_o and mem_we_o read 0.
- R2: With no exception pending, fetch_valid_i sampled at an edge sets stage 0 valid after that edge. Each valid bit moves one stage deeper (bit s to bit s+1) per cycle.
- R3: A flagged exception in a valid stage s has the following effects at the next edge:
  - every stage younger than s (index below s) is invalidated and fetch is blocked;
  - the excepting instruction and the older instructions move on one stage.
- R4: When several valid stages flag in one cycle, the deepest stage wins. Its PC and cause are the ones saved.
- R5: An exception recorded for a younger instruction is replaced when an older (deeper) instruction flags afterwards.
- R6: An exception flag on a stage whose valid bit is 0 has no effect.
- R7: Commit and redirect:
  - The exception commits in the cycle the excepting instruction is in stage 4.
  - In the next cycle, redirect_o is 1 for exactly that one cycle, redirect_pc_o equals HANDLER_PC, and all stage valid bits are 0.
  - epc_o and cause_o show the saved PC and cause and hold until the next commit.
- R8: rf_we_o equals rf_we_i when stage 4 is valid and is not the excepting instruction. It is 0 when stage 4 holds the excepting instruction.
- R9: mem_we_o equals mem_we_i when stage 3 is valid and no exception is tracked in stage 3 or 4. An exception in a younger stage does not block it.
- R10: When the tracked instruction flags again in a later stage, the first PC and cause are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | A new instruction enters stage 0 |
| exc_i | input | 5 | Exception flag per stage, bit s = stage s |
| exc_cause_i | input | 20 | Cause of stage s in bits [4s+3:4s] |
| stage_pc_i | input | 160 | PC of stage s in bits [32s+31:32s] |
| rf_we_i | input | 1 | Register write request from stage 4 |
| mem_we_i | input | 1 | Memory write request from stage 3 |
| stage_valid_o | output | 5 | Valid bit per stage |
| rf_we_o | output | 1 | Gated register write enable |
| mem_we_o | output | 1 | Gated memory write enable |
| redirect_o | output | 1 | One-cycle fetch redirect |
| redirect_pc_o | output | 32 | Handler vector |
| epc_o | output | 32 | Saved resume PC |
| cause_o | output | 4 | Saved cause code |

## Verification
The gated write enables depend on the inputs of the same cycle, so they are checked in that cycle. Stage valid bits change one edge after the inputs that cause them. The redirect, saved PC and cause appear one edge after the cycle in which the excepting instruction holds stage 4, which is three edges after a flag raised in execute. Each expectation is queued with the exact cycle it falls due. The monitor compares it half a period after that cycle's rising edge, and it reports as missed any expectation whose cycle passes without a match.

// File: rtl/exc_flush_pkg.sv
package exc_flush_pkg;
  localparam int unsigned NSTAGE  = 5;
  localparam int unsigned SW      = $clog2(NSTAGE);
  localparam int unsigned MEM_STG = 3;
  localparam int unsigned WB_STG  = NSTAGE - 1;

  typedef logic [SW-1:0] stg_t;
endpackage

// File: rtl/exc_oldest_pick.sv
module exc_oldest_pick
  import exc_flush_pkg::*;
(
  input  logic [NSTAGE-1:0] req_i,
  output logic              found_o,
  output stg_t              idx_o
);
  // ascending scan: the last hit is the deepest stage
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int s = 0; s < NSTAGE; s++) begin
      if (req_i[s]) begin
        found_o = 1'b1;
        idx_o   = stg_t'(s);
      end
    end
  end
endmodule

// File: rtl/exc_valid_pipe.sv
module exc_valid_pipe
  import exc_flush_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic              kill_en_i,
  input  stg_t              kill_stg_i,
  output logic [NSTAGE-1:0] valid_o
);
  logic [NSTAGE-1:0] valid_d, valid_q;

  assign valid_d[0] = fetch_valid_i & ~kill_en_i;

  for (genvar s = 1; s < NSTAGE; s++) begin : g_shift
    // stage s-1 survives only if it is not younger than the tracked one
    assign valid_d[s] = valid_q[s-1] & ~(kill_en_i && (stg_t'(s-1) < kill_stg_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/exc_track.sv
module exc_track
  import exc_flush_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               new_v_i,
  input  stg_t               new_stg_i,
  input  logic [PC_W-1:0]    new_pc_i,
  input  logic [CAUSE_W-1:0] new_cause_i,
  output logic               eff_v_o,
  output stg_t               eff_stg_o,
  output logic               pend_v_o,
  output stg_t               pend_stg_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               pend_v_q;
  stg_t               pend_stg_q;
  logic [PC_W-1:0]    pend_pc_q, epc_q, eff_pc;
  logic [CAUSE_W-1:0] pend_cause_q, cause_q, eff_cause;
  logic               take_new, commit, redirect_q;

  // strictly older only: a repeat flag by the tracked instruction keeps its first record
  assign take_new  = new_v_i && (!pend_v_q || (new_stg_i > pend_stg_q));
  assign eff_v_o   = new_v_i | pend_v_q;
  assign eff_stg_o = take_new ? new_stg_i   : pend_stg_q;
  assign eff_pc    = take_new ? new_pc_i    : pend_pc_q;
  assign eff_cause = take_new ? new_cause_i : pend_cause_q;
  assign commit    = eff_v_o && (eff_stg_o == stg_t'(WB_STG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q     <= 1'b0;
      pend_stg_q   <= '0;
      pend_pc_q    <= '0;
      pend_cause_q <= '0;
      epc_q        <= '0;
      cause_q      <= '0;
      redirect_q   <= 1'b0;
    end else begin
      redirect_q <= commit;
      if (commit) begin
        pend_v_q <= 1'b0;
        epc_q    <= eff_pc;
        cause_q  <= eff_cause;
      end else if (eff_v_o) begin
        pend_v_q     <= 1'b1;
        pend_stg_q   <= eff_stg_o + stg_t'(1);
        pend_pc_q    <= eff_pc;
        pend_cause_q <= eff_cause;
      end
    end
  end

  assign pend_v_o   = pend_v_q;
  assign pend_stg_o = pend_stg_q;
  assign redirect_o = redirect_q;
  assign epc_o      = epc_q;
  assign cause_o    = cause_q;

  assert_epc_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(epc_o) |-> redirect_o);
  assert_redirect_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);
endmodule

// File: rtl/exc_flush_ctrl.sv
module exc_flush_ctrl
  import exc_flush_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned CAUSE_W    = 4,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fetch_valid_i,
  input  logic [NSTAGE-1:0]         exc_i,
  input  logic [NSTAGE*CAUSE_W-1:0] exc_cause_i,
  input  logic [NSTAGE*PC_W-1:0]    stage_pc_i,
  input  logic                      rf_we_i,
  input  logic                      mem_we_i,
  output logic [NSTAGE-1:0]         stage_valid_o,
  output logic                      rf_we_o,
  output logic                      mem_we_o,
  output logic                      redirect_o,
  output logic [PC_W-1:0]           redirect_pc_o,
  output logic [PC_W-1:0]           epc_o,
  output logic [CAUSE_W-1:0]        cause_o
);
  logic [NSTAGE-1:0] valid, pend_lo_mask;
  logic              new_v, eff_v, pend_v;
  stg_t              new_stg, eff_stg, pend_stg;

  exc_oldest_pick u_pick (
    .req_i   (exc_i & valid),
    .found_o (new_v),
    .idx_o   (new_stg)
  );

  exc_track #(.PC_W(PC_W), .CAUSE_W(CAUSE_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .new_v_i     (new_v),
    .new_stg_i   (new_stg),
    .new_pc_i    (stage_pc_i[new_stg*PC_W +: PC_W]),
    .new_cause_i (exc_cause_i[new_stg*CAUSE_W +: CAUSE_W]),
    .eff_v_o     (eff_v),
    .eff_stg_o   (eff_stg),
    .pend_v_o    (pend_v),
    .pend_stg_o  (pend_stg),
    .redirect_o  (redirect_o),
    .epc_o       (epc_o),
    .cause_o     (cause_o)
  );

  exc_valid_pipe u_vpipe (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_valid_i (fetch_valid_i),
    .kill_en_i     (eff_v),
    .kill_stg_i    (eff_stg),
    .valid_o       (valid)
  );

  assign rf_we_o  = rf_we_i  & valid[WB_STG]
                  & ~(eff_v && (eff_stg == stg_t'(WB_STG)));
  assign mem_we_o = mem_we_i & valid[MEM_STG]
                  & ~(eff_v && (eff_stg >= stg_t'(MEM_STG)));

  assign stage_valid_o = valid;
  assign redirect_pc_o = HANDLER_PC;

  always_comb begin
    for (int s = 0; s < NSTAGE; s++) pend_lo_mask[s] = (stg_t'(s) < pend_stg);
  end

  assert_younger_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_v |-> ((valid & pend_lo_mask) == '0));
  assert_tracked_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_v |-> valid[pend_stg]);
  assert_redirect_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (valid == '0));
  assert_rf_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v && pend_stg == stg_t'(WB_STG)) |-> !rf_we_o);
  assert_mem_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v && pend_stg >= stg_t'(MEM_STG)) |-> !mem_we_o);
endmodule

// File: tb/exc_flush_ctrl_tb.sv
`timescale 1ns/1ps
module exc_flush_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] HANDLER = 32'h0000_0180;

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic         fetch_valid_i, rf_we_i, mem_we_i;
  logic [4:0]   exc_i;
  logic [19:0]  exc_cause_i;
  logic [159:0] stage_pc_i;
  logic [4:0]   stage_valid_o;
  logic         rf_we_o, mem_we_o, redirect_o;
  logic [31:0]  redirect_pc_o, epc_o;
  logic [3:0]   cause_o;

  exc_flush_ctrl #(.HANDLER_PC(HANDLER)) u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct { int due; int sel; logic [31:0] val; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [31:0] pcf(int c, int s);
    return 32'h4000_0000 | (32'(c) << 8) | 32'(s);
  endfunction

  task automatic push(int due, int sel, logic [31:0] val, string tag);
    exp_t e;
    e.due = due; e.sel = sel; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive(logic fv, logic [4:0] ex, logic rw, logic mw);
    @(negedge clk_i);
    fetch_valid_i = fv; exc_i = ex; rf_we_i = rw; mem_we_i = mw;
    for (int s = 0; s < 5; s++) stage_pc_i[s*32 +: 32] = pcf(cyc, s);
  endtask

  task automatic fill();
    for (int i = 0; i < 5; i++) begin
      drive(1'b1, 5'b0, 1'b0, 1'b0);
      push(cyc + 1, 0, (32'd1 << (i + 1)) - 1, "R2 valid shift");
    end
  endtask

  function automatic logic [31:0] pick(int sel);
    case (sel)
      0: return 32'(stage_valid_o);
      1: return 32'(redirect_o);
      2: return epc_o;
      3: return 32'(cause_o);
      4: return 32'(rf_we_o);
      5: return 32'(mem_we_o);
      default: return redirect_pc_o;
    endcase
  endfunction

  // monitor
  initial begin
    forever begin
      @(negedge clk_i); #1;
      for (int i = 0; i < q.size(); ) begin
        if (q[i].due <= cyc) begin
          logic [31:0] act;
          act = pick(q[i].sel);
          n_chk++;
          if (q[i].due < cyc || act !== q[i].val) begin
            n_fail++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", q[i].tag, q[i].sel, act, q[i].val);
          end
          q.delete(i);
        end else i++;
      end
    end
  end

  initial begin
    int c0;
    fetch_valid_i = 0; exc_i = 0; rf_we_i = 1; mem_we_i = 1; stage_pc_i = '0;
    for (int s = 0; s < 5; s++) exc_cause_i[s*4 +: 4] = 4'(s + 1);
    repeat (3) @(negedge clk_i);
    push(cyc, 0, 0, "R1 valid"); push(cyc, 1, 0, "R1 redirect");
    push(cyc, 2, 0, "R1 epc");   push(cyc, 3, 0, "R1 cause");
    push(cyc, 4, 0, "R1 rf_we"); push(cyc, 5, 0, "R1 mem_we");
    #2 rst_ni = 1;

    // A: exception in execute
    fill();
    drive(1, 5'b00000, 1, 1);
    push(cyc, 4, 1, "R8 rf write passes"); push(cyc, 5, 1, "R9 mem write passes");
    drive(1, 5'b00100, 1, 1); c0 = cyc;
    push(cyc, 5, 1, "R9 older mem write"); push(cyc, 4, 1, "R8 older rf write");
    push(cyc + 1, 0, 32'b11000, "R3 younger killed");
    drive(1, 5'b00000, 1, 1);
    push(cyc, 5, 0, "R9 excepting mem blocked"); push(cyc, 4, 1, "R8 older rf write");
    push(cyc + 1, 0, 32'b10000, "R3 fetch blocked");
    drive(1, 5'b00000, 1, 1);
    push(cyc, 4, 0, "R8 excepting rf blocked");
    push(cyc + 1, 1, 1, "R7 redirect"); push(cyc + 1, 2, pcf(c0, 2), "R7 epc");
    push(cyc + 1, 3, 3, "R7 cause");    push(cyc + 1, 0, 0, "R7 pipe empty");
    push(cyc + 1, 6, HANDLER, "R7 handler pc");
    drive(0, 5'b00000, 0, 0);
    push(cyc + 1, 1, 0, "R7 single pulse"); push(cyc + 1, 2, pcf(c0, 2), "R7 epc held");
    drive(0, 5'b10000, 0, 0);
    push(cyc + 1, 1, 0, "R6 invalid flag ignored"); push(cyc + 1, 2, pcf(c0, 2), "R6 epc kept");

    // B: two flags in one cycle
    fill();
    drive(1, 5'b01010, 0, 0); c0 = cyc;
    push(cyc + 1, 0, 32'b10000, "R4 younger killed");
    drive(0, 5'b00000, 0, 0);
    push(cyc + 1, 1, 1, "R4 redirect"); push(cyc + 1, 2, pcf(c0, 3), "R4 epc deepest");
    push(cyc + 1, 3, 4, "R4 cause deepest");
    drive(0, 5'b00000, 0, 0);

    // C: older exception replaces younger record
    fill();
    drive(1, 5'b00010, 0, 0);
    push(cyc + 1, 0, 32'b11100, "R3 decode flag");
    drive(0, 5'b01000, 0, 0); c0 = cyc;
    push(cyc + 1, 0, 32'b10000, "R5 kill on older flag");
    drive(0, 5'b00000, 0, 0);
    push(cyc + 1, 1, 1, "R5 redirect"); push(cyc + 1, 2, pcf(c0, 3), "R5 epc replaced");
    push(cyc + 1, 3, 4, "R5 cause replaced");
    drive(0, 5'b00000, 0, 0);

    // D: tracked instruction flags again
    fill();
    drive(1, 5'b00010, 0, 0); c0 = cyc;
    push(cyc + 1, 0, 32'b11100, "R10 first flag");
    drive(0, 5'b00100, 0, 0);
    push(cyc + 1, 0, 32'b11000, "R10 repeat flag");
    drive(0, 5'b00000, 0, 0);
    push(cyc + 1, 0, 32'b10000, "R10 reaches wb");
    drive(0, 5'b00000, 0, 0);
    push(cyc + 1, 1, 1, "R10 redirect"); push(cyc + 1, 2, pcf(c0, 1), "R10 first epc");
    push(cyc + 1, 3, 2, "R10 first cause");
    drive(0, 5'b00000, 0, 0);

    repeat (3) @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule